// File: doc/BRIEF.md
# Serial DAC Write Master

This block drives a three-wire serial link to a 12-bit voltage-output converter. On a start request it latches a 2-bit operating mode and a 12-bit code. It builds a 16-bit command word and shifts it out most significant bit first. Bits leave on a serial clock divided down from the system clock, framed by an active-low frame select. The receiver samples data on falling serial-clock edges, so the master changes data only together with a rising edge.

Between transfers the frame select, serial clock and data all rest low to save receiver input current. Each transfer therefore starts by raising frame select for a guaranteed gap and then dropping it. A transfer ends by holding frame select low for a short time after the last falling edge, raising it for the same gap, and returning it low. A per-transfer option splits the word into two 8-clock bursts, with the clock parked low between them and frame select kept low across both, as an 8-bit host port would do. A one-cycle done pulse marks the return to idle. A start that arrives while a transfer is running is dropped.

Top module: `dac_wr_master`

## Requirements
- R1: After reset and whenever no transfer runs, fs_no, sclk_o, sdo_o and done_o are all 0.
- R2: A transfer carries exactly 16 bits, most significant first. The bits are 2'b00, then mode_i[1:0], then code_i[11:0], with the inputs taken in the cycle start_i is accepted.
- R3: sdo_o changes only in the cycle sclk_o rises, or in the cycle fs_no rises at the end of a transfer. It is stable while sclk_o is high and across each falling edge.
- R4: Inside a burst, each sclk_o high phase and each low phase lasts exactly CLK_DIV/2 system clocks.
- R5: Every high interval of fs_no, both before and after a transfer, lasts exactly GAP_CYC system clocks, and sclk_o is low while fs_no is high.
- R6: fs_no rises exactly CLK_DIV/2 + HOLD_CYC system clocks after the 16th falling edge of sclk_o.
- R7: With byte_mode_i = 1 at start, the low phase between the 8th falling edge and the 9th rising edge lasts CLK_DIV/2 + GAP_CYC clocks, and fs_no stays low.
- R8: start_i asserted while a transfer runs has no effect: the word sent, its timing and the single done pulse are those of the running transfer.
- R9: done_o is a one-cycle pulse, high exactly D cycles after the clock edge that accepted start_i. Here D = 2*GAP_CYC + 33*(CLK_DIV/2) + HOLD_CYC, plus GAP_CYC in byte mode.
- R10: The first rising edge of sclk_o comes exactly CLK_DIV/2 clocks after fs_no falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Transfer request, sampled when idle |
| byte_mode_i | input | 1 | Send as two 8-clock bursts |
| mode_i | input | 2 | Operating-mode field of the word |
| code_i | input | 12 | Converter code field of the word |
| fs_no | output | 1 | Frame select, active low, low at idle |
| sclk_o | output | 1 | Divided serial clock, low at idle |
| sdo_o | output | 1 | Serial data, low at idle |
| done_o | output | 1 | One-cycle end-of-transfer pulse |

## Verification
Every output is decoded from registered state, so a line reacts in the first cycle after the clock edge that changes that state. The done pulse appears D cycles after the edge that accepted start_i. The bench samples all lines at falling system-clock edges and stamps each observation with a count of rising edges. From the bench's own start stamp it then predicts the exact cycle of the done pulse. A line monitor measures every high run, low run and hold interval as a number of observations and compares it with the count that the requirements give. The frame checks run only a few cycles after the predicted done cycle, once all of that frame's lines have settled.

// File: rtl/dac_wr_pkg.sv
package dac_wr_pkg;
  localparam int unsigned MODE_W  = 2;
  localparam int unsigned CODE_W  = 12;
  localparam int unsigned PAD_W   = 2;
  localparam int unsigned FRAME_W = PAD_W + MODE_W + CODE_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SETUP,
    ST_HI,
    ST_LO,
    ST_BGAP,
    ST_HOLD,
    ST_TRAIL
  } wr_state_e;

  function automatic logic [FRAME_W-1:0] pack_word(input logic [MODE_W-1:0] m,
                                                   input logic [CODE_W-1:0] c);
    return {{PAD_W{1'b0}}, m, c};
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned r;
    r = (a > b) ? a : b;
    return (r > c) ? r : c;
  endfunction
endpackage

// File: rtl/dac_phase_timer.sv
module dac_phase_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  p_tmr_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !zero_o) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));
endmodule

// File: rtl/dac_word_shifter.sv
module dac_word_shifter #(
  parameter int unsigned W   = 16,
  parameter int unsigned SCW = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [W-1:0]   word_i,
  input  logic           shift_i,
  output logic           msb_o,
  output logic [SCW-1:0] sent_o
);
  logic [W-1:0]   word_q;
  logic [SCW-1:0] sent_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      sent_q <= '0;
    end else if (load_i) begin
      word_q <= word_i;
      sent_q <= '0;
    end else if (shift_i) begin
      word_q <= {word_q[W-2:0], 1'b0};
      sent_q <= sent_q + 1'b1;
    end
  end

  assign msb_o  = word_q[W-1];
  assign sent_o = sent_q;

  p_sent_cap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sent_q <= SCW'(W));
  p_no_overshift_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |-> (sent_q < SCW'(W)));
endmodule

// File: rtl/dac_wr_fsm.sv
module dac_wr_fsm
  import dac_wr_pkg::*;
#(
  parameter int unsigned HALF  = 4,
  parameter int unsigned GAP   = 5,
  parameter int unsigned HOLD  = 3,
  parameter int unsigned W     = 16,
  parameter int unsigned CNT_W = 3,
  parameter int unsigned SCW   = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             byte_mode_i,
  input  logic             tmr_zero_i,
  input  logic             msb_i,
  input  logic [SCW-1:0]   sent_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             sh_load_o,
  output logic             sh_shift_o,
  output logic             fs_no,
  output logic             sclk_o,
  output logic             sdo_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] T_HALF = CNT_W'(HALF - 1);
  localparam logic [CNT_W-1:0] T_GAP  = CNT_W'(GAP - 1);
  localparam logic [CNT_W-1:0] T_HOLD = CNT_W'(HOLD - 1);
  localparam logic [SCW-1:0]   N_ALL  = SCW'(W);
  localparam logic [SCW-1:0]   N_HALF = SCW'(W / 2);

  wr_state_e state_q, state_d;
  logic      bm_q, sdo_q, done_q;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    sh_load_o  = 1'b0;
    sh_shift_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_LEAD; tmr_load_o = 1'b1; tmr_val_o = T_GAP; sh_load_o = 1'b1;
      end
      ST_LEAD: if (tmr_zero_i) begin
        state_d = ST_SETUP; tmr_load_o = 1'b1; tmr_val_o = T_HALF;
      end
      ST_SETUP: if (tmr_zero_i) begin
        state_d = ST_HI; tmr_load_o = 1'b1; tmr_val_o = T_HALF; sh_shift_o = 1'b1;
      end
      ST_HI: if (tmr_zero_i) begin
        state_d = ST_LO; tmr_load_o = 1'b1; tmr_val_o = T_HALF;
      end
      ST_LO: if (tmr_zero_i) begin
        tmr_load_o = 1'b1;
        if (sent_i == N_ALL) begin
          state_d = ST_HOLD; tmr_val_o = T_HOLD;
        end else if (bm_q && sent_i == N_HALF) begin
          state_d = ST_BGAP; tmr_val_o = T_GAP;
        end else begin
          state_d = ST_HI; tmr_val_o = T_HALF; sh_shift_o = 1'b1;
        end
      end
      ST_BGAP: if (tmr_zero_i) begin
        state_d = ST_HI; tmr_load_o = 1'b1; tmr_val_o = T_HALF; sh_shift_o = 1'b1;
      end
      ST_HOLD: if (tmr_zero_i) begin
        state_d = ST_TRAIL; tmr_load_o = 1'b1; tmr_val_o = T_GAP;
      end
      ST_TRAIL: if (tmr_zero_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bm_q    <= 1'b0;
      sdo_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_TRAIL) && tmr_zero_i;
      if (state_q == ST_IDLE && start_i) bm_q <= byte_mode_i;
      if (sh_shift_o)                    sdo_q <= msb_i;
      else if (state_d == ST_TRAIL)      sdo_q <= 1'b0;
    end
  end

  assign fs_no  = (state_q == ST_LEAD) || (state_q == ST_TRAIL);
  assign sclk_o = (state_q == ST_HI);
  assign sdo_o  = sdo_q;
  assign done_o = done_q;

  p_idle_lines_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (!sdo_o && !sclk_o));
  p_sdo_hi_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(sdo_o));
  p_fs_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_no |-> !sclk_o);
  p_hold_last_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD) |-> (sent_i == N_ALL));
  p_bgap_mid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BGAP) |-> (bm_q && sent_i == N_HALF));
  p_busy_ignore_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && start_i) |-> !sh_load_o);
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/dac_wr_master.sv
module dac_wr_master
  import dac_wr_pkg::*;
#(
  parameter int unsigned CLK_DIV  = 8,
  parameter int unsigned GAP_CYC  = 5,
  parameter int unsigned HOLD_CYC = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              byte_mode_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              fs_no,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic              done_o
);
  localparam int unsigned HALF  = CLK_DIV / 2;
  localparam int unsigned MAXV  = max3(HALF, GAP_CYC, HOLD_CYC);
  localparam int unsigned CNT_W = $clog2(MAXV + 1);
  localparam int unsigned SCW   = $clog2(FRAME_W + 1);

  logic               tmr_load, tmr_zero, sh_load, sh_shift, sh_msb;
  logic [CNT_W-1:0]   tmr_val;
  logic [SCW-1:0]     sh_sent;
  logic [FRAME_W-1:0] word;

  assign word = pack_word(mode_i, code_i);

  dac_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni, .load_i(tmr_load), .load_val_i(tmr_val), .zero_o(tmr_zero)
  );

  dac_word_shifter #(.W(FRAME_W), .SCW(SCW)) u_shift (
    .clk_i, .rst_ni, .load_i(sh_load), .word_i(word), .shift_i(sh_shift),
    .msb_o(sh_msb), .sent_o(sh_sent)
  );

  dac_wr_fsm #(
    .HALF(HALF), .GAP(GAP_CYC), .HOLD(HOLD_CYC), .W(FRAME_W), .CNT_W(CNT_W), .SCW(SCW)
  ) u_fsm (
    .clk_i, .rst_ni, .start_i, .byte_mode_i,
    .tmr_zero_i(tmr_zero), .msb_i(sh_msb), .sent_i(sh_sent),
    .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
    .sh_load_o(sh_load), .sh_shift_o(sh_shift),
    .fs_no, .sclk_o, .sdo_o, .done_o
  );

  p_idle_fs_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!fs_no && !sclk_o && !sdo_o));
endmodule

// File: tb/dac_wr_master_tb.sv
module dac_wr_master_tb_top;
  localparam int CLK_DIV = 8;
  localparam int GAP     = 5;
  localparam int HOLD    = 3;
  localparam int HALF    = CLK_DIV / 2;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        start_i = 1'b0, byte_mode_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [11:0] code_i = '0;
  logic        fs_no, sclk_o, sdo_o, done_o;

  dac_wr_master #(.CLK_DIV(CLK_DIV), .GAP_CYC(GAP), .HOLD_CYC(HOLD)) dut_i (
    .clk_i, .rst_ni, .start_i, .byte_mode_i, .mode_i, .code_i,
    .fs_no, .sclk_o, .sdo_o, .done_o
  );

  always #4 clk_i = ~clk_i;

  int nchk = 0, nfail = 0, cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic int frame_len(input bit bm);
    return 2 * GAP + 33 * HALF + HOLD + (bm ? GAP : 0);
  endfunction

  // line monitor
  bit mon_en = 0, cur_bm = 0, in_frame = 0, lead_ph = 0;
  logic p_sclk = 0, p_fs = 0, p_sdo = 0, p_done = 0;
  int fs_hi_run = 0, lo_run = 0, hi_run = 0, hold_run = 0, rx_cnt = 0;
  logic [15:0] rx_word = '0, f_word = '0;
  int f_bits = 0, f_hold = 0, done_cnt = 0, done_cyc = 0;
  int bad_clk = 0, bad_bgap = 0, bad_gap = 0, bad_sdo = 0, bad_idle = 0, bad_done = 0,
      bad_setup = 0;

  always @(negedge clk_i) if (mon_en) begin
    bit rise_s, fall_s, fs_rise, fs_fall;
    int exp_lo;
    rise_s  = sclk_o && !p_sclk;
    fall_s  = !sclk_o && p_sclk;
    fs_rise = fs_no && !p_fs;
    fs_fall = !fs_no && p_fs;
    if (fs_no) fs_hi_run++;
    if (fs_no && sclk_o) bad_clk++;
    if (fs_fall) begin
      if (fs_hi_run != GAP) bad_gap++;
      fs_hi_run = 0;
      if (!lead_ph) begin
        lead_ph = 1; in_frame = 1; lo_run = 1; rx_cnt = 0; rx_word = '0;
      end else lead_ph = 0;
    end else if (in_frame && !fs_no) begin
      if (rise_s) begin
        exp_lo = (cur_bm && rx_cnt == 8) ? HALF + GAP : HALF;
        if (lo_run != exp_lo) begin
          if (rx_cnt == 0) bad_setup++;
          else if (rx_cnt == 8) bad_bgap++;
          else bad_clk++;
        end
        hi_run = 1;
      end else if (fall_s) begin
        if (hi_run != HALF) bad_clk++;
        rx_word = {rx_word[14:0], sdo_o};
        rx_cnt++;
        lo_run = 1;
        if (rx_cnt == 16) hold_run = 1;
      end else if (sclk_o) hi_run++;
      else begin
        lo_run++;
        if (rx_cnt == 16) hold_run++;
      end
    end
    if (fs_rise && in_frame) begin
      f_word = rx_word; f_bits = rx_cnt; f_hold = hold_run; in_frame = 0;
    end
    if (!in_frame && !fs_no && (sclk_o || sdo_o)) bad_idle++;
    if (sdo_o != p_sdo && !rise_s && !fs_rise) bad_sdo++;
    if (done_o) begin
      if (p_done) bad_done++;
      if (fs_no || sclk_o || sdo_o) bad_idle++;
      done_cnt++;
      done_cyc = cyc;
    end
    p_sclk = sclk_o; p_fs = fs_no; p_sdo = sdo_o; p_done = done_o;
  end

  task automatic run_frame(input logic [1:0] m, input logic [11:0] c, input bit bm,
                           input bit poke);
    int c0, d0, b_clk, b_bg, b_gap, b_sdo, b_idle, b_done, b_set, len;
    logic [15:0] exp_w;
    exp_w = {2'b00, m, c};
    len = frame_len(bm);
    b_clk = bad_clk; b_bg = bad_bgap; b_gap = bad_gap; b_sdo = bad_sdo;
    b_idle = bad_idle; b_done = bad_done; b_set = bad_setup;
    f_bits = 0; f_word = '0; f_hold = 0;
    @(negedge clk_i);
    mode_i = m; code_i = c; byte_mode_i = bm; cur_bm = bm; start_i = 1'b1;
    c0 = cyc; d0 = done_cnt;
    for (int i = 1; i <= len + 3; i++) begin
      @(negedge clk_i);
      start_i = 1'b0;
      if (i == 2) begin mode_i = ~m; code_i = ~c; byte_mode_i = ~bm; end
      if (poke && i == 40) start_i = 1'b1;
    end
    chk(f_bits == 16, "R2 bit count", f_bits, 16);
    chk(f_word == exp_w, "R2 word", f_word, exp_w);
    chk(bad_sdo == b_sdo, "R3 sdo change", bad_sdo - b_sdo, 0);
    chk(bad_clk == b_clk, "R4 clock phases", bad_clk - b_clk, 0);
    chk(bad_gap == b_gap, "R5 fs gap", bad_gap - b_gap, 0);
    chk(f_hold == HALF + HOLD, "R6 hold", f_hold, HALF + HOLD);
    if (bm) chk(bad_bgap == b_bg, "R7 byte gap", bad_bgap - b_bg, 0);
    chk(bad_setup == b_set, "R10 setup", bad_setup - b_set, 0);
    chk(done_cnt - d0 == 1, "R9 done count", done_cnt - d0, 1);
    chk(done_cyc == c0 + len + 1, "R9 done cycle", done_cyc - c0, len + 1);
    chk(bad_done == b_done, "R9 done width", bad_done - b_done, 0);
    chk(bad_idle == b_idle, "R1 idle lines", bad_idle - b_idle, 0);
    if (poke) chk(done_cnt - d0 == 1 && f_word == exp_w, "R8 busy start", f_word, exp_w);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    nfail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2741));
    repeat (3) @(negedge clk_i);
    chk(fs_no == 1'b0, "R1 reset fs", fs_no, 0);
    chk(sclk_o == 1'b0, "R1 reset sclk", sclk_o, 0);
    chk(sdo_o == 1'b0, "R1 reset sdo", sdo_o, 0);
    chk(done_o == 1'b0, "R1 reset done", done_o, 0);
    rst_ni = 1'b1;
    mon_en = 1;
    repeat (4) @(negedge clk_i);
    run_frame(2'b00, 12'h000, 1'b0, 1'b0);
    run_frame(2'b11, 12'hFFF, 1'b0, 1'b0);
    run_frame(2'b01, 12'hA5A, 1'b1, 1'b0);
    run_frame(2'b10, 12'h801, 1'b0, 1'b1);
    run_frame(2'b11, 12'h7FE, 1'b1, 1'b1);
    for (int k = 0; k < 20; k++) begin
      logic [1:0]  rm;
      logic [11:0] rc;
      bit          rb, rp;
      rm = 2'($urandom);
      rc = 12'($urandom);
      rb = 1'($urandom);
      rp = ($urandom % 4) == 0;
      run_frame(rm, rc, rb, rp);
    end
    repeat (20) @(negedge clk_i);
    chk(bad_idle == 0 && fs_no == 1'b0, "R1 final idle", bad_idle, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule